// File: doc/BRIEF.md
# Aliased Control/Status Register

This block is one software-visible 32-bit register built from four fields. A second bus address, the alias, reaches the same field flops and gives each field its own software access mode there. Software sees it through a simple bus: an address, separate write and read valids, write data and byte enables. Read data is combinational. It is valid in the same cycle as the read valid, and every field update takes effect at the next clock edge.

Each field also has a hardware side: a write enable, write data and a continuous output. A field's update logic is a single priority chain. With software priority the order is software write, read side effect, hardware write, pulse clear. With hardware priority the hardware write moves to the front. The field layout is fixed in the package:

| Field | Bits | Primary mode | Alias mode | Winner of same-cycle update | Other |
|---|---|---|---|---|---|
| `ctrl` | 11:0 | read-write | read-only | software | software write needs `sw_gate` high |
| `flags` | 19:12 | write-one-to-clear | write-one-to-set | hardware | — |
| `count` | 27:20 | read-only, clear-on-read | read-only | software | — |
| `kick` | 31:28 | read-write | write-one-to-set | software | single pulse; software write needs `sw_gate` low |

The primary address is 0x10 and the alias address is 0x14. Reset is asynchronous and active-low by default. Parameters can make it synchronous or active-high.

Top module: `regfld_top`

## Requirements
- R1: Only addresses 0x10 (primary) and 0x14 (alias) are decoded. A write to any other address changes no field, and a read there returns zero.
- R2: While `bus_rd` is high at a decoded address, `bus_rdata` shows kick[31:28], count[27:20], flags[19:12] and ctrl[11:0] in the same cycle. While `bus_rd` is low, `bus_rdata` is zero.
- R3: A normal (read-write) software write updates only the field bits whose byte lane has its `bus_be` bit set. `bus_be[k]` covers data bits 8k+7..8k, so ctrl bits 11:8 follow `bus_be[1]`.
- R4: A software write to ctrl takes effect only while `sw_gate` is 1. A software write to kick takes effect only while `sw_gate` is 0.
- R5: A primary write clears each flags bit written as one. An alias write sets each flags bit written as one. Bits written as zero keep their value, and byte enables do not matter in either case.
- R6: A primary read clears count. An alias read leaves count unchanged.
- R7: In a cycle where software and hardware both update a field, the hardware value wins for flags. Software wins for ctrl, count and kick, and the read clear of count counts as a software update.
- R8: Once kick is loaded with a nonzero value, it returns to zero one cycle later unless it is written again. This holds for loads through the primary write, the alias write-one-to-set, and the hardware write.
- R9: An alias write leaves ctrl and count unchanged.
- R10: After reset, ctrl is 0x0A5 and the other fields are zero.
- R11: `hw_we[i]` high loads field i (ctrl=0, flags=1, count=2, kick=3) from the matching bits of `hw_d` at the next edge, unless a higher-priority update occurs in that cycle. A field with no update keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_in | input | 1 | reset, active-low by default |
| bus_addr | input | 8 | bus address |
| bus_wr | input | 1 | write valid |
| bus_rd | input | 1 | read valid |
| bus_wdata | input | 32 | write data |
| bus_be | input | 4 | byte enables |
| bus_rdata | output | 32 | read data, combinational |
| sw_gate | input | 1 | software write qualifier |
| hw_we | input | 4 | hardware write enable per field |
| hw_d | input | 32 | hardware write data, same bit layout as the register |
| fld_q | output | 32 | current field values, same bit layout |

## Verification
Read data is due in the cycle of the request. The bench therefore drives its inputs on the falling edge and samples `bus_rdata` one time unit later, before the next rising edge. Field updates are due one rising edge after the request, so `fld_q` is checked one time unit after that edge, against a model advanced exactly once per cycle. Pulse decay is due one edge later still, and the directed kick checks wait one extra idle cycle to see it.

// File: rtl/regfld_pkg.sv
package regfld_pkg;

    typedef enum logic [2:0] {
        MD_RW,
        MD_RO,
        MD_WO,
        MD_W1C,
        MD_W1S,
        MD_RCLR
    } md_e;

    typedef enum logic [1:0] {
        Q_NONE,
        Q_HIGH,
        Q_LOW
    } qual_e;

    localparam int REG_W = 32;
    localparam int BE_W  = REG_W / 8;
    localparam int NF    = 4;

    localparam int          F_LSB   [NF] = '{0, 12, 20, 28};
    localparam int          F_W     [NF] = '{12, 8, 8, 4};
    localparam md_e         F_PRI   [NF] = '{MD_RW, MD_W1C, MD_RCLR, MD_RW};
    localparam md_e         F_ALI   [NF] = '{MD_RO, MD_W1S, MD_RO, MD_W1S};
    localparam bit          F_HWPRI [NF] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit          F_SP    [NF] = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam qual_e       F_QUAL  [NF] = '{Q_HIGH, Q_NONE, Q_NONE, Q_LOW};
    localparam bit          F_HASRST[NF] = '{1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [31:0] F_RST   [NF] = '{32'h0A5, 32'h0, 32'h0, 32'h0};

    function automatic logic md_readable(md_e m);
        return m != MD_WO;
    endfunction

    function automatic logic md_writable(md_e m);
        return (m == MD_RW) || (m == MD_WO) || (m == MD_W1C) || (m == MD_W1S);
    endfunction

endpackage

// File: rtl/regfld_dec.sv
module regfld_dec #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] ALI_ADDR = 8'h14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              pri_wr,
    output logic              pri_rd,
    output logic              ali_wr,
    output logic              ali_rd,
    output logic              hit
);
    logic pri_sel;
    logic ali_sel;

    always_comb begin
        pri_sel = (addr == PRI_ADDR);
        ali_sel = (addr == ALI_ADDR);
        pri_wr  = pri_sel & wr;
        pri_rd  = pri_sel & rd;
        ali_wr  = ali_sel & wr;
        ali_rd  = ali_sel & rd;
        hit     = pri_sel | ali_sel;
    end
endmodule

// File: rtl/regfld_field.sv
module regfld_field
    import regfld_pkg::*;
#(
    parameter int           W         = 8,
    parameter md_e          PRI_MD    = MD_RW,
    parameter md_e          ALI_MD    = MD_RO,
    parameter bit           HW_PRIO   = 1'b0,
    parameter bit           SP        = 1'b0,
    parameter qual_e        QUAL      = Q_NONE,
    parameter bit           HAS_RST   = 1'b1,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter bit           ASYNC_RST = 1'b1,
    parameter bit           RST_LOW   = 1'b1
) (
    input  logic         clk,
    input  logic         rst_in,
    input  logic         pri_wr,
    input  logic         pri_rd,
    input  logic         ali_wr,
    input  logic         ali_rd,
    input  logic         sw_gate,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wmask,
    input  logic         hw_we,
    input  logic [W-1:0] hw_d,
    output logic [W-1:0] q
);
    logic         rst_act;
    logic         gate_ok;
    logic         sw_pri;
    logic         sw_ali;
    logic         sw_fire;
    logic         rclr;
    md_e          sw_md;
    logic [W-1:0] sw_val;
    logic [W-1:0] nxt;

    assign rst_act = RST_LOW ? ~rst_in : rst_in;

    always_comb begin
        case (QUAL)
            Q_HIGH:  gate_ok = sw_gate;
            Q_LOW:   gate_ok = ~sw_gate;
            default: gate_ok = 1'b1;
        endcase
        sw_pri  = pri_wr & md_writable(PRI_MD) & gate_ok;
        sw_ali  = ali_wr & md_writable(ALI_MD) & gate_ok;
        sw_fire = sw_pri | sw_ali;
        sw_md   = sw_pri ? PRI_MD : ALI_MD;
        rclr    = (pri_rd & (PRI_MD == MD_RCLR)) | (ali_rd & (ALI_MD == MD_RCLR));
        if (sw_md == MD_W1C)      sw_val = q & ~wdata;
        else if (sw_md == MD_W1S) sw_val = q | wdata;
        else                      sw_val = (q & ~wmask) | (wdata & wmask);
    end

    // one priority chain per field; order picked by HW_PRIO
    always_comb begin
        nxt = q;
        if (HW_PRIO && hw_we) nxt = hw_d;
        else if (sw_fire)     nxt = sw_val;
        else if (rclr)        nxt = '0;
        else if (hw_we)       nxt = hw_d;
        else if (SP)          nxt = '0;
    end

    generate
        if (HAS_RST && ASYNC_RST) begin : g_arst
            always_ff @(posedge clk or posedge rst_act) begin
                if (rst_act) q <= RST_VAL;
                else         q <= nxt;
            end
        end else if (HAS_RST) begin : g_srst
            always_ff @(posedge clk) begin
                if (rst_act) q <= RST_VAL;
                else         q <= nxt;
            end
        end else begin : g_nrst
            always_ff @(posedge clk) q <= nxt;
        end
    endgenerate

    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst_act)
        (sw_fire && sw_md == MD_W1C && !(HW_PRIO && hw_we)) |=> ((q & $past(wdata)) == '0));

    p_w1s_sets_r5: assert property (@(posedge clk) disable iff (rst_act)
        (sw_fire && sw_md == MD_W1S && !(HW_PRIO && hw_we)) |=> ((q & $past(wdata)) == $past(wdata)));

    p_hw_wins_r7: assert property (@(posedge clk) disable iff (rst_act)
        (HW_PRIO && hw_we) |=> (q == $past(hw_d)));

    p_read_clear_r6: assert property (@(posedge clk) disable iff (rst_act)
        (rclr && !sw_fire && !(HW_PRIO && hw_we)) |=> (q == '0));

    p_pulse_decay_r8: assert property (@(posedge clk) disable iff (rst_act)
        (SP && !sw_fire && !hw_we) |=> (q == '0));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst_act)
        (!SP && !sw_fire && !rclr && !hw_we) |=> $stable(q));
endmodule

// File: rtl/regfld_top.sv
module regfld_top
    import regfld_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PRI_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] ALI_ADDR  = 8'h14,
    parameter bit                ASYNC_RST = 1'b1,
    parameter bit                RST_LOW   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              sw_gate,
    input  logic [NF-1:0]     hw_we,
    input  logic [REG_W-1:0]  hw_d,
    output logic [REG_W-1:0]  fld_q
);
    logic             pri_wr;
    logic             pri_rd;
    logic             ali_wr;
    logic             ali_rd;
    logic             hit;
    logic             rst_act;
    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] rd_pri;
    logic [REG_W-1:0] rd_ali;

    assign rst_act = RST_LOW ? ~rst_in : rst_in;

    regfld_dec #(
        .ADDR_W   (ADDR_W),
        .PRI_ADDR (PRI_ADDR),
        .ALI_ADDR (ALI_ADDR)
    ) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .pri_wr (pri_wr),
        .pri_rd (pri_rd),
        .ali_wr (ali_wr),
        .ali_rd (ali_rd),
        .hit    (hit)
    );

    for (genvar b = 0; b < REG_W; b++) begin : g_lane
        assign lane_mask[b] = bus_be[b / 8];
    end

    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam int LSB = F_LSB[i];
        localparam int W   = F_W[i];
        logic [W-1:0] q_i;

        regfld_field #(
            .W         (W),
            .PRI_MD    (F_PRI[i]),
            .ALI_MD    (F_ALI[i]),
            .HW_PRIO   (F_HWPRI[i]),
            .SP        (F_SP[i]),
            .QUAL      (F_QUAL[i]),
            .HAS_RST   (F_HASRST[i]),
            .RST_VAL   (F_RST[i][W-1:0]),
            .ASYNC_RST (ASYNC_RST),
            .RST_LOW   (RST_LOW)
        ) u_fld (
            .clk     (clk),
            .rst_in  (rst_in),
            .pri_wr  (pri_wr),
            .pri_rd  (pri_rd),
            .ali_wr  (ali_wr),
            .ali_rd  (ali_rd),
            .sw_gate (sw_gate),
            .wdata   (bus_wdata[LSB +: W]),
            .wmask   (lane_mask[LSB +: W]),
            .hw_we   (hw_we[i]),
            .hw_d    (hw_d[LSB +: W]),
            .q       (q_i)
        );

        assign fld_q[LSB +: W]  = q_i;
        assign rd_pri[LSB +: W] = md_readable(F_PRI[i]) ? q_i : '0;
        assign rd_ali[LSB +: W] = md_readable(F_ALI[i]) ? q_i : '0;
    end

    always_comb begin
        if (pri_rd)      bus_rdata = rd_pri;
        else if (ali_rd) bus_rdata = rd_ali;
        else             bus_rdata = '0;
    end

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst_act)
        !bus_rd |-> (bus_rdata == '0));

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (rst_act)
        (bus_rd && !hit) |-> (bus_rdata == '0));
endmodule

// File: tb/regfld_top_tb.sv
module regfld_top_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [7:0]  A_PRI = 8'h10;
    localparam logic [7:0]  A_ALI = 8'h14;
    localparam logic [7:0]  A_BAD = 8'h18;
    localparam int          WATCHDOG = 100000;

    // bench mode codes
    localparam int M_RW = 0, M_RO = 1, M_W1C = 3, M_W1S = 4, M_RC = 5;

    logic        clk = 1'b0;
    logic        rst_in = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        sw_gate = 1'b0;
    logic [3:0]  hw_we = '0;
    logic [31:0] hw_d = '0;
    logic [31:0] fld_q;

    int total = 0;
    int bad = 0;
    logic [31:0] model;
    logic [31:0] last_rd;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    regfld_top u_dut (
        .clk       (clk),
        .rst_in    (rst_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_rdata (bus_rdata),
        .sw_gate   (sw_gate),
        .hw_we     (hw_we),
        .hw_d      (hw_d),
        .fld_q     (fld_q)
    );

    function automatic logic [31:0] fmask(int f);
        case (f)
            0: return 32'h0000_0FFF;
            1: return 32'h000F_F000;
            2: return 32'h0FF0_0000;
            default: return 32'hF000_0000;
        endcase
    endfunction

    function automatic int pmode(int f);
        case (f)
            0: return M_RW;
            1: return M_W1C;
            2: return M_RC;
            default: return M_RW;
        endcase
    endfunction

    function automatic int amode(int f);
        case (f)
            0: return M_RO;
            1: return M_W1S;
            2: return M_RO;
            default: return M_W1S;
        endcase
    endfunction

    function automatic bit wrable(int m);
        return (m == M_RW) || (m == M_W1C) || (m == M_W1S);
    endfunction

    function automatic logic [31:0] model_rd(logic [31:0] cur, logic [7:0] a, logic rd);
        if (!rd) return 32'h0;
        if (a == A_PRI || a == A_ALI) return cur;
        return 32'h0;
    endfunction

    function automatic logic [31:0] model_next(logic [31:0] cur, logic [7:0] a, logic wr, logic rd,
                                               logic [31:0] wd, logic [3:0] be, logic g,
                                               logic [3:0] we, logic [31:0] hd);
        logic [31:0] bm;
        logic [31:0] res;
        res = cur;
        for (int k = 0; k < 32; k++) bm[k] = be[k / 8];
        for (int f = 0; f < 4; f++) begin
            logic [31:0] m;
            logic [31:0] v;
            logic [31:0] swv;
            bit gok, swp, swa, rc, hp, sp;
            int md;
            m   = fmask(f);
            gok = (f == 0) ? g : (f == 3) ? !g : 1'b1;
            swp = wr && a == A_PRI && wrable(pmode(f)) && gok;
            swa = wr && a == A_ALI && wrable(amode(f)) && gok;
            md  = swp ? pmode(f) : amode(f);
            if (md == M_W1C)      swv = cur & ~wd;
            else if (md == M_W1S) swv = cur | wd;
            else                  swv = (cur & ~bm) | (wd & bm);
            rc = (rd && a == A_PRI && pmode(f) == M_RC) || (rd && a == A_ALI && amode(f) == M_RC);
            hp = (f == 1);
            sp = (f == 3);
            v = cur;
            if (hp && we[f])      v = hd;
            else if (swp || swa)  v = swv;
            else if (rc)          v = 32'h0;
            else if (we[f])       v = hd;
            else if (sp)          v = 32'h0;
            res = (res & ~m) | (v & m);
        end
        return res;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic wr, input logic rd, input logic [31:0] wd,
                       input logic [3:0] be, input logic g, input logic [3:0] we, input logic [31:0] hd);
        logic [31:0] er;
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; bus_be = be;
        sw_gate = g; hw_we = we; hw_d = hd;
        #1;
        last_rd = bus_rdata;
        er = model_rd(model, a, rd);
        chk(last_rd == er, "R2 read data", last_rd, er);
        model = model_next(model, a, wr, rd, wd, be, g, we, hd);
        @(posedge clk);
        #1;
        chk(fld_q == model, "R11 field state", fld_q, model);
    endtask

    task automatic idle();
        cyc(A_PRI, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 4'h0, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model = 32'h0000_00A5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(fld_q == 32'h0000_00A5, "R10 reset in reset", fld_q, 32'h0000_00A5);
        rst_in = 1'b1;
        @(posedge clk);
        #1;
        chk(fld_q == 32'h0000_00A5, "R10 reset values", fld_q, 32'h0000_00A5);

        // R3 byte lanes on ctrl
        cyc(A_PRI, 1, 0, 32'h0000_0FFF, 4'b0001, 1, 4'h0, 32'h0);
        chk(fld_q[11:0] == 12'h0FF, "R3 low lane only", {20'h0, fld_q[11:0]}, 32'h0FF);
        cyc(A_PRI, 1, 0, 32'h0000_0300, 4'b0010, 1, 4'h0, 32'h0);
        chk(fld_q[11:0] == 12'h3FF, "R3 top lane partial", {20'h0, fld_q[11:0]}, 32'h3FF);

        // R4 gate low blocks ctrl
        cyc(A_PRI, 1, 0, 32'h0000_0000, 4'hF, 0, 4'h0, 32'h0);
        chk(fld_q[11:0] == 12'h3FF, "R4 ctrl gated", {20'h0, fld_q[11:0]}, 32'h3FF);

        // R8 kick via primary (gate low allows kick)
        cyc(A_PRI, 1, 0, 32'h5000_0000, 4'b1000, 0, 4'h0, 32'h0);
        chk(fld_q[31:28] == 4'h5, "R8 kick set", {28'h0, fld_q[31:28]}, 32'h5);
        idle();
        chk(fld_q[31:28] == 4'h0, "R8 kick decays", {28'h0, fld_q[31:28]}, 32'h0);

        // R4 gate high blocks kick
        cyc(A_PRI, 1, 0, 32'h7000_0000, 4'b1000, 1, 4'h0, 32'h0);
        chk(fld_q[31:28] == 4'h0, "R4 kick gated", {28'h0, fld_q[31:28]}, 32'h0);

        // R8 kick via alias W1S, R9 ctrl alias read-only
        cyc(A_ALI, 1, 0, 32'hA000_0ABC, 4'hF, 0, 4'h0, 32'h0);
        chk(fld_q[31:28] == 4'hA, "R8 alias pulse", {28'h0, fld_q[31:28]}, 32'hA);
        chk(fld_q[11:0] == 12'h3FF, "R9 alias write ctrl", {20'h0, fld_q[11:0]}, 32'h3FF);
        idle();
        chk(fld_q[31:28] == 4'h0, "R8 alias pulse decays", {28'h0, fld_q[31:28]}, 32'h0);

        // R11 hw set flags
        cyc(A_PRI, 0, 0, 32'h0, 4'h0, 0, 4'b0010, 32'h000F_0000);
        chk(fld_q[19:12] == 8'hF0, "R11 hw write flags", {24'h0, fld_q[19:12]}, 32'hF0);

        // R5 W1C primary, W1S alias, byte enables ignored
        cyc(A_PRI, 1, 0, 32'h0003_0000, 4'h0, 1, 4'h0, 32'h0);
        chk(fld_q[19:12] == 8'hC0, "R5 w1c", {24'h0, fld_q[19:12]}, 32'hC0);
        cyc(A_ALI, 1, 0, 32'h0000_5000, 4'h0, 1, 4'h0, 32'h0);
        chk(fld_q[19:12] == 8'hC5, "R5 w1s", {24'h0, fld_q[19:12]}, 32'hC5);

        // R7 hardware priority on flags
        cyc(A_PRI, 1, 0, 32'h000F_F000, 4'h0, 1, 4'b0010, 32'h0001_1000);
        chk(fld_q[19:12] == 8'h11, "R7 hw beats sw", {24'h0, fld_q[19:12]}, 32'h11);

        // R11 count load
        cyc(A_PRI, 0, 0, 32'h0, 4'h0, 0, 4'b0100, 32'h07E0_0000);
        chk(fld_q[27:20] == 8'h7E, "R11 hw write count", {24'h0, fld_q[27:20]}, 32'h7E);

        // R2 alias read layout, R6 alias read keeps count, R9
        cyc(A_ALI, 0, 1, 32'h0, 4'h0, 0, 4'h0, 32'h0);
        chk(last_rd == 32'h07E1_13FF, "R2 alias read layout", last_rd, 32'h07E1_13FF);
        chk(fld_q[27:20] == 8'h7E, "R6 alias read no clear", {24'h0, fld_q[27:20]}, 32'h7E);
        cyc(A_ALI, 1, 0, 32'h0AB0_0000, 4'hF, 1, 4'h0, 32'h0);
        chk(fld_q[27:20] == 8'h7E, "R9 alias write count", {24'h0, fld_q[27:20]}, 32'h7E);

        // R6 + R7 primary read clears despite hw write
        cyc(A_PRI, 0, 1, 32'h0, 4'h0, 0, 4'b0100, 32'h0550_0000);
        chk(last_rd == 32'h07E1_13FF, "R2 primary read layout", last_rd, 32'h07E1_13FF);
        chk(fld_q[27:20] == 8'h00, "R6 R7 read clear wins", {24'h0, fld_q[27:20]}, 32'h0);

        // R7 software wins on ctrl
        cyc(A_PRI, 1, 0, 32'h0000_0123, 4'b0011, 1, 4'b0001, 32'h0000_0ABC);
        chk(fld_q[11:0] == 12'h123, "R7 sw beats hw", {20'h0, fld_q[11:0]}, 32'h123);

        // R1 unmapped
        cyc(A_BAD, 1, 0, 32'hFFFF_FFFF, 4'hF, 1, 4'h0, 32'h0);
        chk(fld_q == 32'h0001_1123, "R1 unmapped write", fld_q, 32'h0001_1123);
        cyc(A_BAD, 0, 1, 32'h0, 4'h0, 1, 4'h0, 32'h0);
        chk(last_rd == 32'h0, "R1 unmapped read", last_rd, 32'h0);
        cyc(A_PRI, 0, 0, 32'h0, 4'h0, 1, 4'h0, 32'h0);
        chk(last_rd == 32'h0, "R2 no read zero", last_rd, 32'h0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            int sel;
            sel = $urandom_range(0, 3);
            a = (sel == 0) ? A_PRI : (sel == 1) ? A_ALI : (sel == 2) ? A_BAD : 8'($urandom());
            cyc(a, 1'($urandom()), 1'($urandom()), $urandom(), 4'($urandom()), 1'($urandom()),
                4'($urandom() & $urandom()), $urandom());
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R11 actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule